// File: doc/BRIEF.md
# SPI Controller Host-Side Register Front End

This block is the register side of a programmable SPI controller. A host reaches it through a plain 32-bit register port (byte address, write strobe, read strobe, write data, registered read data). Behind the port sit three FIFOs. A 16-bit command queue feeds the instruction sequencer. A 32-bit transmit queue feeds the shift engine. A 32-bit receive queue collects the words the shift engine returns. The sequencer and the shift engine attach through valid/ready ports.

The block reports free space in the two outbound queues and the fill level of the inbound queue. It latches the 8-bit identifier of the last sync event that the sequencer signals. It raises one interrupt line from four sticky pending bits, each masked by its own enable bit. Three of the pending bits come from queue watermarks and the fourth comes from the sync event. A soft-reset register stalls the engine side and empties all three queues for as long as it holds 1.

Top module: `spi_host_frontend`

## Requirements
- R1: After `rst`, the enable register reads 0, `irq` is 0, both room registers read DEPTH (16), the receive level reads 0, the sync identifier reads 0 and the soft-reset register reads 0.
- R2: A write to 0xE0 queues `bus_wdata[15:0]` as a command. Commands leave on `cmd_data` in write order, one per cycle in which `cmd_valid` and `cmd_ready` are both high. 0xD0 reads DEPTH minus the command count.
- R3: A write to 0xE4 queues a transmit word. Transmit words leave on `tx_data` in write order under `tx_valid`/`tx_ready`. 0xD4 reads DEPTH minus the transmit count.
- R4: The block accepts a receive word when `rx_valid` and `rx_ready` are both high. 0xD8 reads the receive count. A read at 0xE8 returns the oldest word and removes it. A read at 0xEC returns the oldest word and leaves the count unchanged.
- R5: A write to a full queue is discarded and changes no count. A read at 0xE8 with the receive queue empty returns 0 and leaves the count at 0.
- R6: Pending bit 0 becomes 1 in any cycle in which the command count is at most MARGIN (4). Pending bit 1 does the same for the transmit count. Pending bit 2 becomes 1 in any cycle in which the receive count is at least DEPTH-MARGIN (12). These bits stay 1 after the condition goes away.
- R7: Writing 0x84 clears each pending bit whose data bit is 1. A bit whose watermark condition still holds reads 1 again.
- R8: A cycle with `sync_valid` high stores `sync_id_in`, which 0xC0 then reads, and sets pending bit 3.
- R9: 0x80 reads back the 4-bit enable register. 0x88 reads pending AND enable. `irq` is high exactly when that masked value is non-zero.
- R10: Writing 1 to 0x40 sets `engine_hold`, empties all three queues, and holds `cmd_valid`, `tx_valid` and `rx_ready` low. Writing 0 releases them. 0x40 reads back the stored bit.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| engine_hold | output | 1 | Soft-reset state toward the engine |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Sequencer takes a command |
| cmd_data | output | 16 | Head command word |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Shift engine takes a word |
| tx_data | output | 32 | Head transmit word |
| rx_valid | input | 1 | Receive word offered |
| rx_ready | output | 1 | Receive queue accepts |
| rx_data | input | 32 | Offered receive word |
| sync_valid | input | 1 | Sync event strobe |
| sync_id_in | input | 8 | Sync event identifier |

## Verification
The bench builds the block with DEPTH 16 and MARGIN 4. With these values a run of sixteen register writes fills a queue, so the dropped-push case can be reached. Thirteen receive words cross the almost-full mark at twelve. Both watermark edges, the empty pop and the flush during hold are reached within a few hundred cycles. A scoreboard compares the order of words on both outbound ports against the writes, including the case where the queue is emptied by the hold.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 16;
    localparam int SYNC_W = 8;

    // Register offsets; the host software depends on these values
    localparam logic [ADDR_W-1:0] OFF_HOLD     = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_IRQ_PEND = 8'h84;
    localparam logic [ADDR_W-1:0] OFF_IRQ_SRC  = 8'h88;
    localparam logic [ADDR_W-1:0] OFF_SYNC     = 8'hC0;
    localparam logic [ADDR_W-1:0] OFF_CMD_ROOM = 8'hD0;
    localparam logic [ADDR_W-1:0] OFF_TX_ROOM  = 8'hD4;
    localparam logic [ADDR_W-1:0] OFF_RX_LVL   = 8'hD8;
    localparam logic [ADDR_W-1:0] OFF_CMD_PUSH = 8'hE0;
    localparam logic [ADDR_W-1:0] OFF_TX_PUSH  = 8'hE4;
    localparam logic [ADDR_W-1:0] OFF_RX_POP   = 8'hE8;
    localparam logic [ADDR_W-1:0] OFF_RX_PEEK  = 8'hEC;

    // Interrupt vector; sync is bit 3, command watermark bit 0
    typedef struct packed {
        logic sync_hit;
        logic rx_high;
        logic tx_low;
        logic cmd_low;
    } irq_bits_t;

    function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v);
        return v;
    endfunction

endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign level   = count;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + LW'(do_push) - LW'(do_pop);
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (flush)
        count <= LW'(DEPTH));

    // R5
    full_push_chk: assert property (@(posedge clk) disable iff (flush)
        (push && full && !pop) |=> (count == $past(count)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (flush)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq
    import spi_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_bits_t set_bits,
    input  logic      clr_we,
    input  irq_bits_t clr_bits,
    input  logic      en_we,
    input  irq_bits_t en_bits,
    output irq_bits_t pending,
    output irq_bits_t enable,
    output irq_bits_t source,
    output logic      irq
);
    irq_bits_t clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;
    assign source  = pending & enable;
    assign irq     = |source;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            enable  <= '0;
        end else begin
            pending <= (pending & ~clr_eff) | set_bits;
            if (en_we) enable <= en_bits;
        end
    end

    // R7
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits.sync_hit && !set_bits.sync_hit) |=> !pending.sync_hit);

endmodule

// File: rtl/spi_host_frontend.sv
module spi_host_frontend
    import spi_fe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              engine_hold,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [15:0]       cmd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [31:0]       rx_data,
    input  logic              sync_valid,
    input  logic [7:0]        sync_id_in
);
    localparam int LW = $clog2(DEPTH) + 1;
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] LOW_MARK = LW'(MARGIN);
    localparam logic [LW-1:0] HI_MARK  = LW'(DEPTH - MARGIN);

    logic              hold_q, flush;
    logic [SYNC_W-1:0] sync_q;
    logic [LW-1:0]     cmd_lvl, tx_lvl, rx_lvl;
    logic              cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head, rd_mux;
    irq_bits_t         set_bits, pending, enable, source;

    assign flush       = rst || hold_q;
    assign engine_hold = hold_q;

    function automatic logic wr_hit(input logic [ADDR_W-1:0] off);
        return bus_wr && (bus_addr == off);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else if (wr_hit(OFF_HOLD)) hold_q <= bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else if (sync_valid) sync_q <= sync_id_in;
    end

    assign cmd_valid = !cmd_empty && !hold_q;
    assign tx_valid  = !tx_empty && !hold_q;
    assign rx_ready  = !rx_full && !hold_q;

    spi_fe_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd (
        .clk(clk), .flush(flush),
        .push(wr_hit(OFF_CMD_PUSH)), .din(bus_wdata[CMD_W-1:0]),
        .pop(cmd_valid && cmd_ready), .dout(cmd_data),
        .full(cmd_full), .empty(cmd_empty), .level(cmd_lvl));

    spi_fe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .flush(flush),
        .push(wr_hit(OFF_TX_PUSH)), .din(bus_wdata),
        .pop(tx_valid && tx_ready), .dout(tx_data),
        .full(tx_full), .empty(tx_empty), .level(tx_lvl));

    spi_fe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .flush(flush),
        .push(rx_valid && rx_ready), .din(rx_data),
        .pop(bus_rd && (bus_addr == OFF_RX_POP)), .dout(rx_head),
        .full(rx_full), .empty(rx_empty), .level(rx_lvl));

    always_comb begin
        set_bits.cmd_low  = (cmd_lvl <= LOW_MARK);
        set_bits.tx_low   = (tx_lvl <= LOW_MARK);
        set_bits.rx_high  = (rx_lvl >= HI_MARK);
        set_bits.sync_hit = sync_valid;
    end

    spi_fe_irq u_irq (
        .clk(clk), .rst(rst), .set_bits(set_bits),
        .clr_we(wr_hit(OFF_IRQ_PEND)), .clr_bits(irq_bits_t'(bus_wdata[3:0])),
        .en_we(wr_hit(OFF_IRQ_EN)), .en_bits(irq_bits_t'(bus_wdata[3:0])),
        .pending(pending), .enable(enable), .source(source), .irq(irq));

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_HOLD:     rd_mux = widen({31'd0, hold_q});
            OFF_IRQ_EN:   rd_mux = widen({28'd0, enable});
            OFF_IRQ_PEND: rd_mux = widen({28'd0, pending});
            OFF_IRQ_SRC:  rd_mux = widen({28'd0, source});
            OFF_SYNC:     rd_mux = widen({24'd0, sync_q});
            OFF_CMD_ROOM: rd_mux = widen(DATA_W'(FULL_LVL - cmd_lvl));
            OFF_TX_ROOM:  rd_mux = widen(DATA_W'(FULL_LVL - tx_lvl));
            OFF_RX_LVL:   rd_mux = widen(DATA_W'(rx_lvl));
            OFF_RX_POP,
            OFF_RX_PEEK:  rd_mux = rx_head;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R8
    sync_latch_chk: assert property (@(posedge clk) disable iff (rst)
        sync_valid |=> (sync_q == $past(sync_id_in)) && pending.sync_hit);

    // R10
    hold_flush_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |=> (cmd_lvl == '0) && (tx_lvl == '0) && (rx_lvl == '0));

    // R10
    hold_gate_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> !cmd_valid && !tx_valid && !rx_ready);

endmodule

// File: tb/tb_spi_host_frontend.sv
module tb_spi_host_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int MARGIN = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, engine_hold;
    logic        cmd_valid, cmd_ready = 1'b0;
    logic [15:0] cmd_data;
    logic        tx_valid, tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [31:0] rx_data = '0;
    logic        sync_valid = 1'b0;
    logic [7:0]  sync_id_in = '0;

    int errors = 0;
    int checks = 0;
    logic [15:0] cmd_q[$];
    logic [31:0] tx_q[$];
    logic [31:0] rd_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_host_frontend #(.DEPTH(DEPTH), .MARGIN(MARGIN)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq(irq), .engine_hold(engine_hold),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sync_valid(sync_valid), .sync_id_in(sync_id_in));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Driver side of the scoreboard
    task automatic push_cmd(input logic [15:0] v, input bit expect_kept);
        if (expect_kept) cmd_q.push_back(v);
        bus_write(8'hE0, {16'hDEAD, v});
    endtask

    task automatic push_tx(input logic [31:0] v);
        tx_q.push_back(v);
        bus_write(8'hE4, v);
    endtask

    task automatic rx_send(input logic [31:0] v);
        rx_data = v; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Monitor side of the scoreboard: R2 and R3 ordering
    always @(negedge clk) begin
        if (!rst && cmd_valid && cmd_ready) begin
            if (cmd_q.size() == 0) check("R2 unexpected command", {16'd0, cmd_data}, 32'hFFFF_FFFF);
            else check("R2 command order", {16'd0, cmd_data}, {16'd0, cmd_q.pop_front()});
        end
        if (!rst && tx_valid && tx_ready) begin
            if (tx_q.size() == 0) check("R3 unexpected tx word", tx_data, 32'hFFFF_FFFF);
            else check("R3 tx order", tx_data, tx_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 0);
        bus_read(8'h80, rd_v); check("R1 enable", rd_v, 0);
        bus_read(8'hD0, rd_v); check("R1 cmd room", rd_v, DEPTH);
        bus_read(8'hD4, rd_v); check("R1 tx room", rd_v, DEPTH);
        bus_read(8'hD8, rd_v); check("R1 rx level", rd_v, 0);
        bus_read(8'hC0, rd_v); check("R1 sync id", rd_v, 0);
        bus_read(8'h40, rd_v); check("R1 hold", rd_v, 0);

        // R6 empty queues raise bits 0 and 1
        bus_read(8'h84, rd_v); check("R6 pending after reset", rd_v, 32'h3);

        // R9 enable, source and irq
        bus_write(8'h80, 32'h1);
        check("R9 irq on", {31'd0, irq}, 1);
        bus_read(8'h88, rd_v); check("R9 source", rd_v, 32'h1);
        bus_read(8'h80, rd_v); check("R9 enable readback", rd_v, 32'h1);
        bus_write(8'h80, 32'h0);
        check("R9 irq off", {31'd0, irq}, 0);

        // R2 queue five commands with the sequencer stalled
        for (int i = 0; i < 5; i++) push_cmd(16'h1000 + 16'(i), 1'b1);
        bus_read(8'hD0, rd_v); check("R2 cmd room", rd_v, DEPTH - 5);
        bus_read(8'h84, rd_v); check("R6 sticky bit 0", rd_v, 32'h3);
        // R7 clear bit 0 (condition gone) and bit 1 (condition still true)
        bus_write(8'h84, 32'h3);
        bus_read(8'h84, rd_v); check("R7 write-one-to-clear", rd_v, 32'h2);

        // R5 fill the command queue, then one dropped write
        for (int i = 5; i < DEPTH; i++) push_cmd(16'h1000 + 16'(i), 1'b1);
        push_cmd(16'hBEEF, 1'b0);
        bus_read(8'hD0, rd_v); check("R5 cmd room when full", rd_v, 0);
        cmd_ready = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        check("R5 dropped word never delivered", cmd_q.size(), 0);
        check("R2 cmd drained", {31'd0, cmd_valid}, 0);
        cmd_ready = 1'b0;

        // R3 transmit queue room then order
        push_tx(32'hA5A5_0001);
        push_tx(32'hA5A5_0002);
        bus_read(8'hD4, rd_v); check("R3 tx room", rd_v, DEPTH - 2);
        tx_ready = 1'b1;
        push_tx(32'hA5A5_0003);
        repeat (4) @(negedge clk);
        check("R3 tx drained", tx_q.size(), 0);
        tx_ready = 1'b0;

        // R4 receive path
        bus_write(8'h84, 32'hF);
        for (int i = 0; i < 13; i++) rx_send(32'hC000_0000 + 32'(i));
        bus_read(8'hD8, rd_v); check("R4 rx level", rd_v, 13);
        bus_read(8'h84, rd_v); check("R6 rx almost full bit 2", rd_v & 32'h4, 32'h4);
        bus_read(8'hEC, rd_v); check("R4 peek head", rd_v, 32'hC000_0000);
        bus_read(8'hEC, rd_v); check("R4 peek again", rd_v, 32'hC000_0000);
        bus_read(8'hD8, rd_v); check("R4 peek keeps level", rd_v, 13);
        for (int i = 0; i < 13; i++) begin
            bus_read(8'hE8, rd_v); check("R4 pop order", rd_v, 32'hC000_0000 + 32'(i));
        end
        bus_read(8'hE8, rd_v); check("R5 empty pop reads zero", rd_v, 0);
        bus_read(8'hD8, rd_v); check("R5 empty pop keeps level", rd_v, 0);

        // R8 sync event
        sync_id_in = 8'h5A; sync_valid = 1'b1;
        @(negedge clk);
        sync_valid = 1'b0;
        bus_read(8'hC0, rd_v); check("R8 sync id", rd_v, 32'h5A);
        bus_read(8'h84, rd_v); check("R8 sync pending", rd_v & 32'h8, 32'h8);
        bus_write(8'h80, 32'h8);
        check("R9 irq from sync", {31'd0, irq}, 1);
        bus_write(8'h84, 32'h8);
        check("R7 sync cleared drops irq", {31'd0, irq}, 0);
        bus_write(8'h80, 32'h0);

        // R10 soft hold flushes and gates
        for (int i = 0; i < 3; i++) push_cmd(16'h2000 + 16'(i), 1'b1);
        rx_send(32'h1234_5678);
        bus_write(8'h40, 32'h1);
        cmd_q.delete();
        cmd_ready = 1'b1;
        check("R10 engine_hold", {31'd0, engine_hold}, 1);
        check("R10 rx_ready low", {31'd0, rx_ready}, 0);
        check("R10 cmd_valid low", {31'd0, cmd_valid}, 0);
        bus_read(8'h40, rd_v); check("R10 hold readback", rd_v, 1);
        bus_read(8'hD0, rd_v); check("R10 cmd flushed", rd_v, DEPTH);
        bus_read(8'hD8, rd_v); check("R10 rx flushed", rd_v, 0);
        bus_write(8'h40, 32'h0);
        check("R10 released", {31'd0, engine_hold | ~rx_ready}, 0);
        cmd_ready = 1'b0;

        // R11 unmapped address and read latency
        bus_read(8'h10, rd_v); check("R11 unmapped reads zero", rd_v, 0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule